// File: doc/BRIEF.md
# Processor-Bus JTAG Port Bridge

This block places a JTAG chain behind a single location on a microprocessor's address and data bus. Software drives the chain one bit at a time by writing to that location. No general-purpose processor pins are needed. A qualified write loads the clock, mode and data lines of the chain from the low data nibble into three registers. All three therefore change on the same system clock edge. A qualified read returns the chain's test-data-out bit together with the three driven values, so software can check what it is driving.

A select input gives the chain to an external download-cable header. While the header is selected, its clock, mode and data lines go through to the chain, and the chain's data-out bit is passed to the header. The processor registers keep their contents and can still be written and read. The data-strobe input is synchronised to the system clock and edge-detected, so each bus cycle loads the registers once, however long the strobe stays low.

Top module: `jtag_bus_bridge`

## Requirements
- R1: While reset is asserted and the header is not selected, chain_tck is 0, chain_tms is 1, chain_tdi is 0 and rd_oe is 0.
- R2: A qualified write loads the registers from wr_data: bit 0 to the clock, bit 1 to the mode line, bit 2 to the data line. The new values reach the chain pins within four clock cycles of the data strobe going low. A qualified write needs addr equal to BASE_ADDR, addr_strobe high, rd_wr_n low and data_strobe_n low.
- R3: A write with a different address, or with addr_strobe low, leaves the chain pins unchanged.
- R4: One strobe-low period loads the registers exactly once. A change on wr_data while the strobe stays low has no effect, and the chain pins do not change while the strobe is idle.
- R5: During a qualified read (rd_wr_n high), rd_oe is 1. rd_data bit 3 is chain_tdo, bit 2 is the data register, bit 1 is the mode register and bit 0 is the clock register.
- R6: When no qualified read is in progress, rd_oe is 0 and rd_data is 0, including during write cycles.
- R7: While cable_sel is 1, chain_tck, chain_tms and chain_tdi follow cable_tck, cable_tms and cable_tdi. Writes still update the registers, and their values reappear on the chain when cable_sel returns to 0.
- R8: cable_tdo always equals chain_tdo. A read returns chain_tdo in bit 3 whether or not the header is selected.
- R9: A read leaves the registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Bus address |
| addr_strobe | input | 1 | Address valid, active high |
| data_strobe_n | input | 1 | Data strobe, active low |
| rd_wr_n | input | 1 | 1 = read, 0 = write |
| wr_data | input | 4 | Write data nibble |
| rd_data | output | 4 | Read data nibble, 0 when not enabled |
| rd_oe | output | 1 | Read data output enable |
| cable_sel | input | 1 | 1 = the header drives the chain |
| cable_tck | input | 1 | Header clock line |
| cable_tms | input | 1 | Header mode line |
| cable_tdi | input | 1 | Header data line |
| cable_tdo | output | 1 | Chain data-out passed to the header |
| chain_tck | output | 1 | Chain clock |
| chain_tms | output | 1 | Chain mode select |
| chain_tdi | output | 1 | Chain data in |
| chain_tdo | input | 1 | Chain data out |

## Verification
The hardest case to reach is a second load inside a single bus cycle. It takes a data strobe held low well beyond the synchroniser delay while the write data changes under it. The bench holds the strobe low with one nibble, waits until that nibble has reached the pins, then switches to a different nibble for several more cycles. The pins must keep the first value. A similar stimulus writes while the header owns the chain and then hands the chain back, to show the hidden register took the write.

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge #(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hA5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              addr_strobe,
  input  logic              data_strobe_n,
  input  logic              rd_wr_n,
  input  logic [3:0]        wr_data,
  output logic [3:0]        rd_data,
  output logic              rd_oe,
  input  logic              cable_sel,
  input  logic              cable_tck,
  input  logic              cable_tms,
  input  logic              cable_tdi,
  output logic              cable_tdo,
  output logic              chain_tck,
  output logic              chain_tms,
  output logic              chain_tdi,
  input  logic              chain_tdo
);

  logic [2:0] ds_sync;
  logic       hit, ds_act, ds_edge;
  logic       tck_q, tms_q, tdi_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ds_sync <= '0;
    else        ds_sync <= {ds_sync[1:0], ~data_strobe_n};

  assign ds_act  = ds_sync[1];
  assign ds_edge = ds_sync[1] & ~ds_sync[2];
  assign hit     = addr_strobe && (addr == BASE_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tck_q <= 1'b0;
      tms_q <= 1'b1;
      tdi_q <= 1'b0;
    end else if (ds_edge && hit && !rd_wr_n) begin
      tck_q <= wr_data[0];
      tms_q <= wr_data[1];
      tdi_q <= wr_data[2];
    end

  assign rd_oe   = ds_act && hit && rd_wr_n;
  assign rd_data = rd_oe ? {chain_tdo, tdi_q, tms_q, tck_q} : 4'b0000;

  assign chain_tck = cable_sel ? cable_tck : tck_q;
  assign chain_tms = cable_sel ? cable_tms : tms_q;
  assign chain_tdi = cable_sel ? cable_tdi : tdi_q;
  assign cable_tdo = chain_tdo;

endmodule

// File: rtl/jtag_bus_bridge_checker.sv
module jtag_bus_bridge_checker #(
  parameter int              ADDR_W    = 20,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hA5000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_strobe,
  input logic              data_strobe_n,
  input logic              rd_wr_n,
  input logic [3:0]        rd_data,
  input logic              rd_oe,
  input logic              cable_sel,
  input logic              cable_tdo,
  input logic              chain_tck,
  input logic              chain_tms,
  input logic              chain_tdi,
  input logic              chain_tdo
);

  logic [1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              idle_cnt <= '0;
    else if (!data_strobe_n) idle_cnt <= '0;
    else if (idle_cnt != 2'd3) idle_cnt <= idle_cnt + 2'd1;

  p_oe_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rd_wr_n && addr_strobe && addr == BASE_ADDR));

  p_bus_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> rd_data == 4'b0000);

  p_readback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && !cable_sel) |-> rd_data[2:0] == {chain_tdi, chain_tms, chain_tck});

  p_tdo_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe |-> (rd_data[3] == chain_tdo && cable_tdo == chain_tdo));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_cnt == 2'd3 && data_strobe_n && !cable_sel) |=>
      (cable_sel || $stable({chain_tck, chain_tms, chain_tdi})));

endmodule

bind jtag_bus_bridge jtag_bus_bridge_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .addr_strobe(addr_strobe),
  .data_strobe_n(data_strobe_n), .rd_wr_n(rd_wr_n), .rd_data(rd_data),
  .rd_oe(rd_oe), .cable_sel(cable_sel), .cable_tdo(cable_tdo),
  .chain_tck(chain_tck), .chain_tms(chain_tms), .chain_tdi(chain_tdi),
  .chain_tdo(chain_tdo)
);

// File: tb/jtag_bus_bridge_tb.sv
module jtag_bus_bridge_tb;
  localparam int ADDR_W = 20;
  localparam logic [ADDR_W-1:0] BASE = 20'hA5000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic addr_strobe = 1'b0, data_strobe_n = 1'b1, rd_wr_n = 1'b1;
  logic [3:0] wr_data = '0, rd_data;
  logic rd_oe, cable_sel = 1'b0, cable_tck = 1'b0, cable_tms = 1'b0, cable_tdi = 1'b0;
  logic cable_tdo, chain_tck, chain_tms, chain_tdi, chain_tdo = 1'b0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  jtag_bus_bridge #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .addr_strobe(addr_strobe),
    .data_strobe_n(data_strobe_n), .rd_wr_n(rd_wr_n), .wr_data(wr_data),
    .rd_data(rd_data), .rd_oe(rd_oe), .cable_sel(cable_sel),
    .cable_tck(cable_tck), .cable_tms(cable_tms), .cable_tdi(cable_tdi),
    .cable_tdo(cable_tdo), .chain_tck(chain_tck), .chain_tms(chain_tms),
    .chain_tdi(chain_tdi), .chain_tdo(chain_tdo)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] pins();
    return {5'b0, chain_tdi, chain_tms, chain_tck};
  endfunction

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic as, input logic [3:0] d);
    @(negedge clk);
    addr = a; addr_strobe = as; rd_wr_n = 1'b0; wr_data = d; data_strobe_n = 1'b0;
    idle(5);
    data_strobe_n = 1'b1; addr_strobe = 1'b0; rd_wr_n = 1'b1;
    idle(4);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [3:0] d, output logic oe);
    @(negedge clk);
    addr = a; addr_strobe = 1'b1; rd_wr_n = 1'b1; data_strobe_n = 1'b0;
    idle(4);
    d = rd_data; oe = rd_oe;
    data_strobe_n = 1'b1; addr_strobe = 1'b0;
    idle(4);
  endtask

  task automatic t_reset;
    check("R1 pins in reset", pins(), 8'h02);
    check("R1 oe in reset", {7'b0, rd_oe}, 8'h00);
  endtask

  task automatic t_write;
    bus_write(BASE, 1'b1, 4'b0101);
    check("R2 write 0101", pins(), 8'h05);
    bus_write(BASE, 1'b1, 4'b0010);
    check("R2 write 0010", pins(), 8'h02);
    bus_write(BASE, 1'b1, 4'b1111);
    check("R2 write 1111", pins(), 8'h07);
  endtask

  task automatic t_ignored;
    bus_write(BASE ^ 20'h00010, 1'b1, 4'b0000);
    check("R3 wrong address", pins(), 8'h07);
    bus_write(BASE, 1'b0, 4'b0000);
    check("R3 no addr strobe", pins(), 8'h07);
  endtask

  task automatic t_once;
    @(negedge clk);
    addr = BASE; addr_strobe = 1'b1; rd_wr_n = 1'b0; wr_data = 4'b0001; data_strobe_n = 1'b0;
    idle(5);
    check("R4 first load", pins(), 8'h01);
    wr_data = 4'b0110;
    idle(6);
    check("R4 no reload", pins(), 8'h01);
    data_strobe_n = 1'b1; addr_strobe = 1'b0; rd_wr_n = 1'b1;
    idle(4);
    check("R4 after release", pins(), 8'h01);
  endtask

  task automatic t_read;
    logic [3:0] d; logic oe;
    bus_write(BASE, 1'b1, 4'b0110);
    chain_tdo = 1'b1;
    bus_read(BASE, d, oe);
    check("R5 read data", {4'b0, d}, 8'h0E);
    check("R5 read oe", {7'b0, oe}, 8'h01);
    check("R9 regs after read", pins(), 8'h06);
    chain_tdo = 1'b0;
    bus_read(BASE, d, oe);
    check("R5 read tdo low", {4'b0, d}, 8'h06);
    bus_read(BASE ^ 20'h80000, d, oe);
    check("R6 wrong address read", {3'b0, oe, d}, 8'h00);
    @(negedge clk);
    addr = BASE; addr_strobe = 1'b1; rd_wr_n = 1'b0; wr_data = 4'b0110; data_strobe_n = 1'b0;
    idle(4);
    check("R6 oe during write", {3'b0, rd_oe, rd_data}, 8'h00);
    data_strobe_n = 1'b1; addr_strobe = 1'b0; rd_wr_n = 1'b1;
    idle(4);
  endtask

  task automatic t_cable;
    logic [3:0] d; logic oe;
    @(negedge clk);
    cable_sel = 1'b1; cable_tck = 1'b1; cable_tms = 1'b0; cable_tdi = 1'b1;
    @(negedge clk);
    check("R7 cable drives chain", pins(), 8'h05);
    bus_write(BASE, 1'b1, 4'b0011);
    check("R7 write hidden", pins(), 8'h05);
    chain_tdo = 1'b1;
    @(negedge clk);
    check("R8 tdo to header", {7'b0, cable_tdo}, 8'h01);
    bus_read(BASE, d, oe);
    check("R8 read tdo under cable", {3'b0, oe, d}, 8'h1B);
    cable_sel = 1'b0;
    @(negedge clk);
    check("R7 regs restored", pins(), 8'h03);
    chain_tdo = 1'b0;
    @(negedge clk);
    check("R8 tdo low to header", {7'b0, cable_tdo}, 8'h00);
  endtask

  initial begin
    idle(3);
    t_reset;
    rst_n = 1'b1;
    idle(2);
    t_write;
    t_ignored;
    t_once;
    t_read;
    t_cable;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule